// File: doc/BRIEF.md
# Software-Triggered ADC Acquisition Sequencer

This block is the control logic of a four-channel, 16-bit analog input module that a host reaches through a byte-wide register interface. The host first sets the module-enable bit. It then writes one or more channel-list entries, each selecting an input channel, a gain code, the multiplexer enable and the on-board-only flag. It also loads a settling count and a settling time base. A conversion starts when the host reads the trigger offset. That read has a side effect, and no write is needed.

When a conversion starts, the sequencer copies the current channel-list entry onto the analog front-end control outputs. It then waits out the settling time, which is the loaded count multiplied by the prescale that the time base selects. Next it raises a request to an external converter and holds that request until the converter reports completion. The 16-bit sample is captured as it arrives, already in two's complement, and the host reads it back as a low byte and a high byte. The pending flag in the status register is set when a conversion starts and clears when the sample has been captured. Error bits record a trigger that arrives while a conversion is still running and a start made with a zero settling count. A channel scanner steps through the list after each conversion.

Top module: `adc_seq`

## Requirements
- R1: After reset the status register (0x12) reads 0x00, the result bytes (0x02, 0x03) read 0x00, the scan index (0x14) reads 0 and adcReq and all front-end outputs are low. Status bit2 (pacer error) always reads 0.
- R2: The module enable is bit2 of register 0x10. A read of 0x04 while the module is disabled leaves the status unchanged, raises no adcReq and leaves the front-end outputs unchanged.
- R3: A read of 0x04 while the module is enabled and idle sets status bit7 (pending). On the same clock edge it drives the current channel-list entry onto the front-end outputs. The entry is decoded as bit5 = onboardOnly, bits[4:3] = gainCode, bit2 = muxEna and bits[1:0] = muxChan.
- R4: adcReq rises exactly C*P+1 clock edges after the edge that samples the trigger read. C is the count in register 0x15, and P is 1, 4, 16 or 64 for time base 0, 1, 2 or 3 in bits[2:1] of register 0x11.
- R5: When adcDone is high while adcReq is high, adcData is captured. On that edge status bit7 clears and adcReq falls. The sample then reads unchanged at 0x02 (bits 7:0) and 0x03 (bits 15:8).
- R6: A read of 0x04 while a conversion is pending is ignored, meaning the wait is not restarted, and it sets status bit1 (data error). Any write to 0x12 clears status bits 1 and 0.
- R7: Starting a conversion with a settling count of 0 sets status bit0 (settling error), and adcReq rises one edge after the start.
- R8: A write to 0x1B during the settling wait reloads the wait. adcReq then rises C*P+1 edges after that write edge.
- R9: Channel-list entry k is written at 0x80+k. After each completed conversion the scan index (0x14) advances and wraps to 0 after entry N-1. N is the value in register 0x13, clamped to 1..depth. A write to 0x19 sets the scan index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register offset |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdEn | input | 1 | Register read strobe (reading 0x04 starts a conversion) |
| busRdData | output | 8 | Register read data, combinational from busAddr |
| adcReq | output | 1 | Sample request to the external converter |
| adcDone | input | 1 | Converter completion, valid while adcReq is high |
| adcData | input | 16 | Converter sample, two's complement |
| muxChan | output | 2 | Selected input channel |
| gainCode | output | 2 | Selected gain code |
| muxEna | output | 1 | Input multiplexer enable |
| onboardOnly | output | 1 | On-board input restriction |

## Verification
A stuck or mis-sequenced controller state shows up at the ports right away. It appears as status bit7 disagreeing with adcReq, or as adcReq rising off its exact C*P+1 edge, so the directed cases count edges from the trigger to the request for every time base. A wrong scan index is not visible until the next conversion applies the wrong channel. For that reason the scanner cases check both the index register and the front-end outputs at the following start. Error bits that are set or cleared wrongly show in the next status read, and every error case makes that read before the bits are cleared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int SAMPLE_W = 16;
  localparam int PRE_W    = 6;

  localparam logic [7:0] ADDR_RES_LO  = 8'h02;
  localparam logic [7:0] ADDR_RES_HI  = 8'h03;
  localparam logic [7:0] ADDR_TRIG    = 8'h04;
  localparam logic [7:0] ADDR_CONF    = 8'h10;
  localparam logic [7:0] ADDR_OPT     = 8'h11;
  localparam logic [7:0] ADDR_STATUS  = 8'h12;
  localparam logic [7:0] ADDR_LASTCH  = 8'h13;
  localparam logic [7:0] ADDR_SCANIDX = 8'h14;
  localparam logic [7:0] ADDR_SETTLE  = 8'h15;
  localparam logic [7:0] ADDR_SCANRST = 8'h19;
  localparam logic [7:0] ADDR_CNTRST  = 8'h1B;
  localparam logic [7:0] ADDR_LIST    = 8'h80;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_REQ    = 2'd2
  } seqState_t;

  typedef struct packed {
    logic applyEntry;
    logic capture;
    logic advance;
  } seqStrb_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       busAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic             modEnable,
  input  logic [1:0]       timeBase,
  input  logic [CNT_W-1:0] settleCount,
  input  logic             adcDone,
  output logic             adcReq,
  output logic [7:0]       statusByte,
  output seqStrb_t         strb
);

  seqState_t        state;
  logic [CNT_W-1:0] remain;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             errData;
  logic             errSettle;
  logic             startRd;
  logic             statusWr;
  logic             cntRstWr;
  logic             launch;

  always_comb begin
    startRd  = busRdEn && (busAddr == ADDR_TRIG);
    statusWr = busWrEn && (busAddr == ADDR_STATUS);
    cntRstWr = busWrEn && (busAddr == ADDR_CNTRST);
    launch   = (state == SEQ_IDLE) && startRd && modEnable;
  end

  always_comb begin
    case (timeBase)
      2'd0:    preLimit = PRE_W'(0);
      2'd1:    preLimit = PRE_W'(3);
      2'd2:    preLimit = PRE_W'(15);
      default: preLimit = PRE_W'(63);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      remain    <= '0;
      preCnt    <= '0;
      errData   <= 1'b0;
      errSettle <= 1'b0;
    end else begin
      if (statusWr) begin
        errData   <= 1'b0;
        errSettle <= 1'b0;
      end
      case (state)
        SEQ_IDLE: begin
          if (launch) begin
            state  <= SEQ_SETTLE;
            remain <= settleCount;
            preCnt <= '0;
            if (settleCount == '0) errSettle <= 1'b1;
          end
        end
        SEQ_SETTLE: begin
          if (startRd) errData <= 1'b1;
          if (cntRstWr) begin
            remain <= settleCount;
            preCnt <= '0;
          end else if (remain == '0) begin
            state <= SEQ_REQ;
          end else if (preCnt == preLimit) begin
            preCnt <= '0;
            remain <= remain - 1'b1;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        SEQ_REQ: begin
          if (startRd) errData <= 1'b1;
          if (adcDone) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    adcReq          = (state == SEQ_REQ);
    strb.applyEntry = launch;
    strb.capture    = (state == SEQ_REQ) && adcDone;
    strb.advance    = (state == SEQ_REQ) && adcDone;
    statusByte      = {state != SEQ_IDLE, 4'b0000, 1'b0, errData, errSettle};
  end

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int LIST_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          busAddr,
  input  logic                busWrEn,
  input  logic [7:0]          busWrData,
  input  logic [7:0]          statusByte,
  input  seqStrb_t            strb,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic                modEnable,
  output logic [1:0]          timeBase,
  output logic [CNT_W-1:0]    settleCount,
  output logic [7:0]          busRdData,
  output logic [1:0]          muxChan,
  output logic [1:0]          gainCode,
  output logic                muxEna,
  output logic                onboardOnly
);

  localparam int IDX_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1;
  localparam int USE_W = IDX_W + 1;

  logic [5:0]          listMem [LIST_DEPTH];
  logic [7:0]          lastChan;
  logic [IDX_W-1:0]    scanIdx;
  logic [USE_W-1:0]    useCount;
  logic [SAMPLE_W-1:0] result;
  logic [5:0]          curEntry;
  logic                scanRstWr;

  always_comb begin
    scanRstWr = busWrEn && (busAddr == ADDR_SCANRST);
    curEntry  = listMem[scanIdx];
    if (lastChan == 8'd0)
      useCount = USE_W'(1);
    else if (lastChan > 8'(LIST_DEPTH))
      useCount = USE_W'(LIST_DEPTH);
    else
      useCount = USE_W'(lastChan);
  end

  generate
    for (genvar k = 0; k < LIST_DEPTH; k++) begin : g_list
      always_ff @(posedge clk) begin
        if (!rstN)
          listMem[k] <= '0;
        else if (busWrEn && (busAddr == ADDR_LIST + 8'(k)))
          listMem[k] <= busWrData[5:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modEnable   <= 1'b0;
      timeBase    <= '0;
      settleCount <= '0;
      lastChan    <= '0;
    end else if (busWrEn) begin
      case (busAddr)
        ADDR_CONF:   modEnable   <= busWrData[2];
        ADDR_OPT:    timeBase    <= busWrData[2:1];
        ADDR_SETTLE: settleCount <= CNT_W'(busWrData);
        ADDR_LASTCH: lastChan    <= busWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanIdx <= '0;
    end else if (scanRstWr) begin
      scanIdx <= '0;
    end else if (strb.advance) begin
      if (USE_W'(scanIdx) + USE_W'(1) >= useCount)
        scanIdx <= '0;
      else
        scanIdx <= scanIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxChan     <= '0;
      gainCode    <= '0;
      muxEna      <= 1'b0;
      onboardOnly <= 1'b0;
    end else if (strb.applyEntry) begin
      onboardOnly <= curEntry[5];
      gainCode    <= curEntry[4:3];
      muxEna      <= curEntry[2];
      muxChan     <= curEntry[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      result <= '0;
    else if (strb.capture)
      result <= adcData;
  end

  always_comb begin
    busRdData = 8'h00;
    case (busAddr)
      ADDR_RES_LO:  busRdData = result[7:0];
      ADDR_RES_HI:  busRdData = result[15:8];
      ADDR_CONF:    busRdData = {5'b0, modEnable, 2'b0};
      ADDR_OPT:     busRdData = {5'b0, timeBase, 1'b0};
      ADDR_STATUS:  busRdData = statusByte;
      ADDR_LASTCH:  busRdData = lastChan;
      ADDR_SCANIDX: busRdData = 8'(scanIdx);
      ADDR_SETTLE:  busRdData = 8'(settleCount);
      default: begin
        for (int k = 0; k < LIST_DEPTH; k++)
          if (busAddr == ADDR_LIST + 8'(k)) busRdData = {2'b00, listMem[k]};
      end
    endcase
  end

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int LIST_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          busAddr,
  input  logic                busWrEn,
  input  logic [7:0]          busWrData,
  input  logic                busRdEn,
  output logic [7:0]          busRdData,
  output logic                adcReq,
  input  logic                adcDone,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic [1:0]          muxChan,
  output logic [1:0]          gainCode,
  output logic                muxEna,
  output logic                onboardOnly
);

  logic             modEnable;
  logic [1:0]       timeBase;
  logic [CNT_W-1:0] settleCount;
  logic [7:0]       statusByte;
  seqStrb_t         strb;

  adc_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .modEnable(modEnable), .timeBase(timeBase),
    .settleCount(settleCount), .adcDone(adcDone), .adcReq(adcReq),
    .statusByte(statusByte), .strb(strb)
  );

  adc_seq_dp #(.CNT_W(CNT_W), .LIST_DEPTH(LIST_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .statusByte(statusByte), .strb(strb),
    .adcData(adcData), .modEnable(modEnable), .timeBase(timeBase),
    .settleCount(settleCount), .busRdData(busRdData), .muxChan(muxChan),
    .gainCode(gainCode), .muxEna(muxEna), .onboardOnly(onboardOnly)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busAddr,
  input logic       busRdEn,
  input logic       adcReq,
  input logic       adcDone,
  input logic       modEnable,
  input logic [7:0] statusByte
);

  logic trigRd;
  assign trigRd = busRdEn && (busAddr == 8'h04);

  p_req_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    adcReq |-> statusByte[7]);

  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (adcReq && adcDone) |=> (!statusByte[7] && !adcReq));

  p_busy_trig_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (trigRd && statusByte[7]) |=> statusByte[1]);

  p_disabled_trig_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trigRd && !modEnable && !statusByte[7]) |=> ($stable(statusByte) && !adcReq));

  p_pacer_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[2]);

endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdEn(busRdEn),
  .adcReq(adcReq), .adcDone(adcDone), .modEnable(modEnable),
  .statusByte(statusByte)
);

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
module adc_seq_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic        busWrEn;
  logic [7:0]  busWrData;
  logic        busRdEn;
  logic [7:0]  busRdData;
  logic        adcReq;
  logic        adcDone;
  logic [15:0] adcData;
  logic [1:0]  muxChan;
  logic [1:0]  gainCode;
  logic        muxEna;
  logic        onboardOnly;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  adc_seq u_adc_seq (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .adcReq(adcReq), .adcDone(adcDone), .adcData(adcData),
    .muxChan(muxChan), .gainCode(gainCode), .muxEna(muxEna),
    .onboardOnly(onboardOnly)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic trigger();
    logic [7:0] dummy;
    busRead(8'h04, dummy);
  endtask

  task automatic edgesToReq(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (adcReq) break;
    end
  endtask

  task automatic finishConv(logic [15:0] v);
    @(negedge clk);
    adcData = v; adcDone = 1'b1;
    @(posedge clk); #1;
    adcDone = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(8'h12, d); check("R1 status", d, 8'h00);
    busRead(8'h02, d); check("R1 res lo", d, 8'h00);
    busRead(8'h03, d); check("R1 res hi", d, 8'h00);
    busRead(8'h14, d); check("R1 scan idx", d, 0);
    check("R1 adcReq", adcReq, 0);
    check("R1 front end", {onboardOnly, gainCode, muxEna, muxChan}, 0);
  endtask

  task automatic testDisabled();
    logic [7:0] d;
    busWrite(8'h80, 8'h2E);
    busWrite(8'h15, 8'h02);
    trigger();
    busRead(8'h12, d); check("R2 status unchanged", d, 8'h00);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (adcReq) break;
    end
    check("R2 no request", adcReq, 0);
    check("R2 front end unchanged", {onboardOnly, gainCode, muxEna, muxChan}, 0);
  endtask

  task automatic runConv(string req, logic [1:0] tb, logic [7:0] cnt, int p, logic [15:0] v);
    int n;
    logic [7:0] d;
    busWrite(8'h11, {5'b0, tb, 1'b0});
    busWrite(8'h15, cnt);
    trigger();
    edgesToReq(n);
    check({req, " req timing"}, n, int'(cnt) * p + 1);
    busRead(8'h12, d); check({req, " pending bit7"}, d[7], 1);
    finishConv(v);
    @(negedge clk);
    check("R5 req drops", adcReq, 0);
    busRead(8'h12, d); check("R5 bit7 clear", d[7], 0);
    busRead(8'h02, d); check("R5 low byte", d, v[7:0]);
    busRead(8'h03, d); check("R5 high byte", d, v[15:8]);
  endtask

  task automatic testMain();
    logic [7:0] d;
    int n;
    busWrite(8'h10, 8'h04);
    busWrite(8'h11, 8'h00);
    busWrite(8'h15, 8'h05);
    trigger();
    @(negedge clk);
    check("R3 onboardOnly", onboardOnly, 1);
    check("R3 gainCode", gainCode, 1);
    check("R3 muxEna", muxEna, 1);
    check("R3 muxChan", muxChan, 2);
    busRead(8'h12, d); check("R3 status pending", d, 8'h80);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (adcReq) break;
    end
    finishConv(16'h8123);
    busRead(8'h02, d); check("R5 lo 8123", d, 8'h23);
    busRead(8'h03, d); check("R5 hi 8123", d, 8'h81);
    runConv("R4 tb0", 2'd0, 8'd5, 1, 16'h7FFE);
    runConv("R4 tb1", 2'd1, 8'd3, 4, 16'hFFFF);
    runConv("R4 tb2", 2'd2, 8'd2, 16, 16'h0001);
    runConv("R4 tb3", 2'd3, 8'd1, 64, 16'hA55A);
  endtask

  task automatic testBusyErr();
    logic [7:0] d;
    int n;
    busWrite(8'h11, 8'h00);
    busWrite(8'h15, 8'd20);
    trigger();
    repeat (3) @(posedge clk);
    trigger();
    busRead(8'h12, d); check("R6 busy trigger err", d, 8'h82);
    edgesToReq(n);
    check("R6 wait not restarted", n < 20 ? 1 : 0, 1);
    finishConv(16'h1234);
    busRead(8'h12, d); check("R6 err held", d, 8'h02);
    busWrite(8'h12, 8'h00);
    busRead(8'h12, d); check("R6 err cleared", d, 8'h00);
  endtask

  task automatic testZeroCount();
    logic [7:0] d;
    int n;
    busWrite(8'h15, 8'h00);
    trigger();
    edgesToReq(n);
    check("R7 req after one edge", n, 1);
    busRead(8'h12, d); check("R7 settle err", d, 8'h81);
    finishConv(16'h0F0F);
    busWrite(8'h12, 8'hFF);
    busRead(8'h12, d); check("R7 err cleared", d, 8'h00);
  endtask

  task automatic testCountReset();
    int n;
    busWrite(8'h11, 8'h00);
    busWrite(8'h15, 8'd10);
    trigger();
    repeat (4) @(posedge clk);
    busWrite(8'h1B, 8'h00);
    edgesToReq(n);
    check("R8 reload wait", n, 11);
    finishConv(16'h0000);
  endtask

  task automatic testScanner();
    logic [7:0] d;
    logic [5:0] ent [3] = '{6'h04, 6'h0D, 6'h37};
    busWrite(8'h81, 8'h0D);
    busWrite(8'h82, 8'h37);
    busWrite(8'h80, 8'h04);
    busWrite(8'h13, 8'd3);
    busWrite(8'h15, 8'd1);
    busWrite(8'h19, 8'h00);
    busRead(8'h14, d); check("R9 idx reset", d, 0);
    for (int k = 0; k < 3; k++) begin
      trigger();
      @(negedge clk);
      check("R9 applied entry", {onboardOnly, gainCode, muxEna, muxChan}, ent[k]);
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (adcReq) break;
      end
      finishConv(16'(k));
      busRead(8'h14, d); check("R9 idx advance", d, (k + 1) % 3);
    end
    trigger();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (adcReq) break;
    end
    finishConv(16'h0);
    busRead(8'h14, d); check("R9 idx one", d, 1);
    busWrite(8'h19, 8'h00);
    busRead(8'h14, d); check("R9 idx cleared", d, 0);
  endtask

  initial begin
    rstN = 1'b0; busAddr = '0; busWrEn = 1'b0; busWrData = '0;
    busRdEn = 1'b0; adcDone = 1'b0; adcData = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testDisabled();
    testMain();
    testBusyErr();
    testZeroCount();
    testCountReset();
    testScanner();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule